// File: doc/BRIEF.md
# Level-Sensitive Interrupt Status Controller

This block is the device-side interrupt logic for a peripheral that shares one level-sensitive, active-low interrupt line with other devices. Each completion source raises a sticky pending bit. A per-bit mask selects which pending bits may request service. While any unmasked bit is pending, the block turns on an open-drain pull-down. When none is pending, it releases the line.

Software uses a small register port. It reads the raw pending bits, the mask, and the bits that are actually requesting service. It clears pending bits by writing ones to them. The expected service routine works in this order: check the requesting bits, clear them, do a dummy read so the clear is known to have landed, and only then handle the completed work. If a completion arrives during or after the clear, its bit stays set or sets again, so the line is requested again and the work is never stranded. Bus cycles that carry an interrupt-acknowledge indication are ignored completely, because they are answered by the system interrupt controller.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every pending bit and every mask bit is 0, `irq_oe_o` is 0 (line released) and `rd_valid_o` is 0.
- R2: A 1 on `evt_i[i]` in a cycle sets pending bit i at the next clock edge. The bit then stays set, with no further events, until software clears it.
- R3: A write to address 0x0 clears each pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: If an event on bit i and a clearing write to bit i occur in the same cycle, bit i stays set.
- R5: Address 0x1 holds the mask, which can be read and written. A 1 lets the pending bit drive the line. Reads of address 0x0 return the raw pending bits whatever the mask holds.
- R6: Address 0x2 reads the pending bits ANDed with the mask, which are the bits currently requesting service. Writes to it change nothing.
- R7: `irq_oe_o` is 1 exactly when some bit is both pending and unmasked, as those registers stood one clock earlier. `irq_dout_o` is always 0.
- R8: A read request (`req_valid_i`=1, `req_write_i`=0) gives `rd_valid_o`=1 with `rd_data_o` after the next clock edge. The value already reflects every write accepted in earlier cycles, so a read issued in the cycle after a clear returns the cleared state.
- R9: While `intack_i` is 1, a request writes nothing and produces no read response.
- R10: An event that arrives after its bit has been cleared sets the bit again and drives the line again.
- R11: Reads of any address other than 0x0, 0x1 and 0x2 return 0, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_SRC | Completion events, one per source, active high for one or more cycles |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Register address |
| req_wdata_i | input | N_SRC | Write data |
| intack_i | input | 1 | Marks the current bus cycle as an interrupt acknowledge |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | N_SRC | Read data |
| irq_oe_o | output | 1 | Output enable of the open-drain pull-down (1 = line driven low) |
| irq_dout_o | output | 1 | Data of the open-drain pad, always 0 |

## Verification
An event or a write changes the pending and mask registers at the first clock edge after it is presented. The line enable follows one edge after that. A read response appears at the first edge after the request. The bench drives inputs on falling edges and keeps a behavioural model that it advances at each rising edge in the same order. On every falling edge it compares all outputs with the model. Its directed read tasks sample one falling edge after issuing the request, and its line checks wait one further cycle. Together these show that a clear is already visible to the read that follows it and that a coinciding event survives the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned REG_PEND = 0;
  localparam int unsigned REG_MASK = 1;
  localparam int unsigned REG_ACT  = 2;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ACT  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    wr_clr;
    logic    wr_mask;
    logic    rd;
    rd_sel_e sel;
  } acc_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              intack_i,
  output acc_t              acc_o
);

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(REG_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(REG_ACT);

  logic live;

  always_comb begin
    live = req_valid_i && !intack_i;
    acc_o.wr_clr  = live && req_write_i && (req_addr_i == A_PEND);
    acc_o.wr_mask = live && req_write_i && (req_addr_i == A_MASK);
    acc_o.rd      = live && !req_write_i;
    if (req_addr_i == A_PEND)      acc_o.sel = SEL_PEND;
    else if (req_addr_i == A_MASK) acc_o.sel = SEL_MASK;
    else if (req_addr_i == A_ACT)  acc_o.sel = SEL_ACT;
    else                           acc_o.sel = SEL_NONE;
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [N_SRC-1:0] clr_bits_i,
  input  logic             mask_en_i,
  input  logic [N_SRC-1:0] mask_bits_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] mask_o
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic kill;
    assign kill = clr_en_i && clr_bits_i[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_o[i] <= 1'b0;
      end else begin
        // a new event outranks a clear of the same bit
        pend_o[i] <= evt_i[i] | (pend_o[i] & ~kill);
      end
    end

    always_ff @(posedge clk) begin
      if (rst)            mask_o[i] <= 1'b0;
      else if (mask_en_i) mask_o[i] <= mask_bits_i[i];
    end
  end

endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             oe_o,
  output logic             dout_o
);

  always_ff @(posedge clk) begin
    if (rst) oe_o <= 1'b0;
    else     oe_o <= |(pend_i & mask_i);
  end

  assign dout_o = 1'b0;

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [N_SRC-1:0]  req_wdata_i,
  input  logic              intack_i,
  output logic              rd_valid_o,
  output logic [N_SRC-1:0]  rd_data_o,
  output logic              irq_oe_o,
  output logic              irq_dout_o
);

  acc_t             acc;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] rd_mux;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .intack_i    (intack_i),
    .acc_o       (acc)
  );

  irq_pend_bank #(.N_SRC(N_SRC)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .clr_en_i    (acc.wr_clr),
    .clr_bits_i  (req_wdata_i),
    .mask_en_i   (acc.wr_mask),
    .mask_bits_i (req_wdata_i),
    .pend_o      (pend_q),
    .mask_o      (mask_q)
  );

  irq_line_drv #(.N_SRC(N_SRC)) u_drv (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_q),
    .mask_i (mask_q),
    .oe_o   (irq_oe_o),
    .dout_o (irq_dout_o)
  );

  always_comb begin
    unique case (acc.sel)
      SEL_PEND: rd_mux = pend_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_ACT:  rd_mux = pend_q & mask_q;
      default:  rd_mux = '0;
    endcase
  end

  // register state already holds every earlier write, so the read is ordered
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= acc.rd;
      if (acc.rd) rd_data_o <= rd_mux;
    end
  end

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  evt_i,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              intack_i,
  input logic              rd_valid_o,
  input logic              irq_oe_o,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  mask_q
);

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && mask_q == '0 && !irq_oe_o && !rd_valid_o)); // R1

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (evt_i == '0 && !req_valid_i) |=> $stable(pend_q) && $stable(mask_q)); // R2

  AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & mask_q) != '0) |=> irq_oe_o); // R7

  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & mask_q) == '0) |=> !irq_oe_o); // R7

  AST_RD_RESP: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_write_i && !intack_i) |=> rd_valid_o); // R8

  AST_INTACK_SILENT: assert property (@(posedge clk) disable iff (rst)
    intack_i |=> !rd_valid_o); // R9

  AST_INTACK_NO_STATE: assert property (@(posedge clk) disable iff (rst)
    (intack_i && evt_i == '0) |=> $stable(pend_q) && $stable(mask_q)); // R9

  AST_ODD_ADDR_WR: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_write_i && req_addr_i > ADDR_W'(2) && evt_i == '0)
      |=> $stable(pend_q) && $stable(mask_q)); // R11

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt_i       (evt_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .intack_i    (intack_i),
  .rd_valid_o  (rd_valid_o),
  .irq_oe_o    (irq_oe_o),
  .pend_q      (pend_q),
  .mask_q      (mask_q)
);

// File: tb/lvl_irq_ctrl_tb.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb;

  localparam int N = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  evt = '0;
  logic          rv = 1'b0;
  logic          rw = 1'b0;
  logic [AW-1:0] ra = '0;
  logic [N-1:0]  wd = '0;
  logic          ia = 1'b0;
  logic          rd_valid;
  logic [N-1:0]  rd_data;
  logic          oe;
  logic          dout;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // behavioural reference
  logic [N-1:0] m_pend = '0, m_mask = '0, m_rdd = '0;
  logic         m_oe = 1'b0, m_rdv = 1'b0;

  always #4 clk = ~clk;

  lvl_irq_ctrl #(.N_SRC(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .req_valid_i(rv), .req_write_i(rw),
    .req_addr_i(ra), .req_wdata_i(wd), .intack_i(ia),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .irq_oe_o(oe), .irq_dout_o(dout)
  );

  function automatic logic [N-1:0] view(input int a);
    if (a == 0) return m_pend;
    if (a == 1) return m_mask;
    if (a == 2) return m_pend & m_mask;
    return '0;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] clr;
    if (rst) begin
      m_pend = '0; m_mask = '0; m_oe = 0; m_rdv = 0;
    end else begin
      m_oe  = (m_pend & m_mask) != '0;
      m_rdv = rv && !rw && !ia;
      if (m_rdv) m_rdd = view(int'(ra));
      clr = '0;
      if (rv && rw && !ia) begin
        if (ra == 0) clr = wd;
        if (ra == 1) m_mask = wd;
      end
      m_pend = (m_pend & ~clr) | evt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R7 line", int'(oe), int'(m_oe));
    chk("R7 dout", int'(dout), 0);
    chk("R8 valid", int'(rd_valid), int'(m_rdv));
    if (m_rdv) chk("R8 data", int'(rd_data), int'(m_rdd));
  end

  task automatic wr(input int a, input int d, input logic ack = 0);
    @(negedge clk); rv = 1; rw = 1; ra = AW'(a); wd = N'(d); ia = ack;
    @(negedge clk); rv = 0; rw = 0; ia = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); rv = 1; rw = 0; ra = AW'(a);
    @(negedge clk); rv = 0;
    chk(tag, int'(rd_valid), 1);
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic pulse(input int e);
    @(negedge clk); evt = N'(e);
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cmp_on = 1;
    @(negedge clk); rst = 0;
    chk("R1 line", int'(oe), 0);
    chk("R1 valid", int'(rd_valid), 0);
    rd(0, 0, "R1 pend");
    rd(1, 0, "R1 mask");

    pulse('h05);
    rd(0, 'h05, "R2 set");
    repeat (4) @(negedge clk);
    rd(0, 'h05, "R2 sticky");
    chk("R7 masked off", int'(oe), 0);

    wr(1, 'h04);
    rd(1, 'h04, "R5 mask");
    rd(0, 'h05, "R5 raw");
    rd(2, 'h04, "R6 active");
    chk("R7 asserted", int'(oe), 1);

    wr(0, 'h01);
    rd(0, 'h04, "R3 partial clear");
    // clear then read in the very next cycle
    @(negedge clk); rv = 1; rw = 1; ra = 0; wd = 'h04;
    @(negedge clk); rw = 0; ra = 0;
    @(negedge clk); rv = 0;
    chk("R8 ordered", int'(rd_data), 0);
    @(negedge clk);
    chk("R7 released", int'(oe), 0);

    // event and clear on the same bit in the same cycle
    @(negedge clk); evt = 'h04; rv = 1; rw = 1; ra = 0; wd = 'h04;
    @(negedge clk); evt = 0; rv = 0; rw = 0;
    rd(0, 'h04, "R4 event wins");

    wr(0, 'h04);
    rd(0, 0, "R10 cleared");
    pulse('h04);
    rd(2, 'h04, "R10 re-set");
    chk("R10 line", int'(oe), 1);

    wr(1, 'h00, 1'b1);
    wr(0, 'hFF, 1'b1);
    rd(1, 'h04, "R9 mask kept");
    rd(0, 'h04, "R9 pend kept");
    @(negedge clk); rv = 1; rw = 0; ra = 0; ia = 1;
    @(negedge clk); rv = 0; ia = 0;
    chk("R9 no response", int'(rd_valid), 0);

    wr(2, 'h00);
    rd(2, 'h04, "R6 read-only");
    wr(5, 'hFF);
    rd(1, 'h04, "R11 write ignored");
    rd(5, 0, "R11 read zero");

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      evt = (($urandom % 4) == 0) ? N'($urandom) : '0;
      rv  = ($urandom % 2) == 1;
      rw  = ($urandom % 2) == 1;
      ra  = AW'($urandom % 6);
      wd  = N'($urandom);
      ia  = ($urandom % 8) == 0;
    end
    @(negedge clk); evt = 0; rv = 0; ia = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule